// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the host's transmit-data line and the enable of a bus line driver. The transmit-data bit is active low: a low level asks the driver to hold the bus dominant. The dominant command follows the raw input through gates only, so the transmit path adds no clock latency.

Two fault mechanisms override the host. The first is a dominant-time watchdog. It counts the clock cycles in which a synchronized copy of the transmit line stays low. Once the count reaches a parameterised limit, it withdraws the drive and lets the bus fall back to recessive. A high level on the transmit line clears the count and re-arms the drive. The second is over-temperature shutdown. A raised over-temperature flag kills the drive at once and sets a latch. The latch is released only after the flag has dropped and the transmit line has been seen high, which keeps the driver from toggling as the temperature hovers around the trip point. A mode enable from the mode controller gates the drive without disturbing either mechanism.

Top module: `dom_timeout_guard`

## Requirements
- R1: `drv_dom_o` is 1 in the same cycle exactly when `txd_i` is 0, `mode_en_i` is 1, `overtemp_i` is 0, and neither `timeout_o` nor `thermal_o` is 1. Otherwise it is 0. There is no register on this path.
- R2: `txd_i` passes through a SYNC_STAGES-flop synchronizer into the timer. Suppose `txd_i` is 0 at clock edge k and stays 0. Then `timeout_o` is 0 up to edge k+SYNC_STAGES+TIMEOUT_CYC-2 and is 1 after edge k+SYNC_STAGES+TIMEOUT_CYC-1.
- R3: While `timeout_o` is 1, `drv_dom_o` is 0 regardless of `txd_i`.
- R4: The synchronized transmit line being 1 at any edge clears the timer at that edge. A `txd_i` high level first sampled at edge j clears `timeout_o` after edge j+SYNC_STAGES. A one-cycle high pulse inside a long low run restarts the full timeout window.
- R5: The timer saturates at TIMEOUT_CYC. `timeout_o` stays 1 for any length of continuous low beyond the limit and never wraps back to 0.
- R6: `overtemp_i` at 1 forces `drv_dom_o` to 0 in the same cycle. `thermal_o` is 1 after the next edge.
- R7: After `overtemp_i` returns to 0, `thermal_o` stays 1 until an edge at which the synchronized transmit line is 1. It clears at that edge.
- R8: With `rst_ni` low, `timeout_o` and `thermal_o` are 0, and the synchronizer holds recessive (1).
- R9: `mode_en_i` at 0 forces `drv_dom_o` to 0 but does not stop the timer. A low run that continues while the mode enable is 0 still raises `timeout_o` on the R2 schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| txd_i | input | 1 | Host transmit data, 0 = dominant |
| mode_en_i | input | 1 | Transmit permitted by mode controller |
| overtemp_i | input | 1 | Over-temperature flag, synchronous |
| drv_dom_o | output | 1 | Driver dominant command |
| timeout_o | output | 1 | Dominant timeout has fired |
| thermal_o | output | 1 | Thermal shutdown latched |

## Verification
The dominant command is combinational and is due in the same cycle as its inputs. The thermal latch reacts one edge after the over-temperature flag. The timeout flag rises SYNC_STAGES+TIMEOUT_CYC-1 edges after the first low sample and falls SYNC_STAGES edges after the first high sample. The bench drives inputs just after a rising edge. A behavioural model, built on a sample-history queue and integer counters, advances on every rising edge. All three outputs are compared against that model at each falling edge, so every result is read only after the register that produces it has updated. Directed checks count edges explicitly, sampling one edge before and one edge after the timeout boundary and the clear boundary.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  // 3 ms nominal at 200 MHz
  localparam int unsigned DefTimeoutCyc = 600_000;
  localparam int unsigned DefSyncStages = 2;

  typedef struct packed {
    logic timeout;
    logic thermal;
  } guard_stat_t;
endpackage

// File: rtl/dtg_sync.sv
module dtg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= RST_VAL;
        else         sh_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dtg_timer.sv
module dtg_timer #(
  parameter int unsigned TIMEOUT_CYC = 600_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_s_i,
  output logic expired_o
);
  localparam int unsigned CntW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CntW-1:0] Limit = CntW'(TIMEOUT_CYC);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (txd_s_i)        cnt_q <= '0;
    else if (cnt_q != Limit) cnt_q <= cnt_q + CntW'(1);
  end

  assign expired_o = (cnt_q == Limit);

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txd_s_i && cnt_q != Limit) |=> cnt_q == $past(cnt_q) + CntW'(1));
  // R4
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_s_i |=> cnt_q == '0);
  // R5
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !txd_s_i) |=> expired_o);
endmodule

// File: rtl/dtg_thermal.sv
module dtg_thermal (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic overtemp_i,
  input  logic txd_s_i,
  output logic latched_o
);
  logic lat_q;

  // release needs both a cool die and a recessive transmit line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               lat_q <= 1'b0;
    else if (overtemp_i)       lat_q <= 1'b1;
    else if (lat_q && txd_s_i) lat_q <= 1'b0;
  end

  assign latched_o = lat_q;

  // R6
  thermal_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overtemp_i |=> lat_q);
  // R7
  thermal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && !txd_s_i) |=> lat_q);
endmodule

// File: rtl/dom_timeout_guard.sv
module dom_timeout_guard
  import dtg_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = DefTimeoutCyc,
  parameter int unsigned SYNC_STAGES = DefSyncStages
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic mode_en_i,
  input  logic overtemp_i,
  output logic drv_dom_o,
  output logic timeout_o,
  output logic thermal_o
);
  logic        txd_s;
  guard_stat_t stat;

  dtg_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (txd_i),
    .q_o   (txd_s)
  );

  dtg_timer #(
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .txd_s_i  (txd_s),
    .expired_o(stat.timeout)
  );

  dtg_thermal i_thermal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .overtemp_i(overtemp_i),
    .txd_s_i   (txd_s),
    .latched_o (stat.thermal)
  );

  // raw txd_i on the data path: no sync latency to the bus
  assign drv_dom_o = mode_en_i & ~txd_i & ~overtemp_i & ~stat.timeout & ~stat.thermal;
  assign timeout_o = stat.timeout;
  assign thermal_o = stat.thermal;

  // R3
  timeout_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !drv_dom_o);
  // R6
  overtemp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overtemp_i |-> !drv_dom_o);
  // R7
  thermal_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thermal_o |-> !drv_dom_o);
endmodule

// File: tb/test_dom_timeout_guard.sv
`timescale 1ns/1ps
module test_dom_timeout_guard;
  localparam int T = 40;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic txd = 1'b1, mode_en = 1'b1, ot = 1'b0;
  logic drv_dom, timeout, thermal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dom_timeout_guard #(.TIMEOUT_CYC(T), .SYNC_STAGES(S)) i_dom_timeout_guard (
    .clk_i(clk), .rst_ni(rst_ni), .txd_i(txd), .mode_en_i(mode_en),
    .overtemp_i(ot), .drv_dom_o(drv_dom), .timeout_o(timeout), .thermal_o(thermal)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: sample history queue + run-length counter
  bit hist[$];
  int m_run;
  bit m_th;
  string phase = "R1";

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist.delete();
      for (int i = 0; i < S; i++) hist.push_front(1'b1);
      m_run = 0;
      m_th  = 1'b0;
    end else begin
      bit s_old;
      s_old = hist[$];
      if (!s_old) m_run = (m_run < T) ? m_run + 1 : T;
      else        m_run = 0;
      if (ot)                 m_th = 1'b1;
      else if (m_th && s_old) m_th = 1'b0;
      hist.push_front(txd);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      bit e_to, e_drv;
      e_to  = (m_run >= T);
      e_drv = mode_en && !txd && !ot && !e_to && !m_th;
      chk(timeout == e_to, (phase == "R1") ? "R2" : phase, "timeout_o", timeout, e_to);
      chk(thermal == m_th, "R7", "thermal_o", thermal, m_th);
      chk(drv_dom == e_drv, (phase == "R1") ? "R1" : phase, "drv_dom_o", drv_dom, e_drv);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    // R8: reset state
    step(3);
    chk(timeout == 1'b0, "R8", "timeout_o in reset", timeout, 0);
    chk(thermal == 1'b0, "R8", "thermal_o in reset", thermal, 0);
    rst_ni = 1'b1;
    step(3);
    chk(timeout == 1'b0, "R8", "timeout_o after reset", timeout, 0);

    // R1: ordinary traffic, runs well below the limit
    phase = "R1";
    for (int i = 0; i < 300; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      txd = seed[7];
      step(1 + (seed[12:9] % 6));
    end
    txd = 1'b1; step(4);

    // R2: exact timeout edge
    phase = "R2";
    txd = 1'b0;
    step(S + T - 1);
    chk(timeout == 1'b0, "R2", "timeout_o one edge early", timeout, 0);
    chk(drv_dom == 1'b1, "R1", "drv_dom_o before timeout", drv_dom, 1);
    step(1);
    chk(timeout == 1'b1, "R2", "timeout_o at limit", timeout, 1);
    chk(drv_dom == 1'b0, "R3", "drv_dom_o after timeout", drv_dom, 0);

    // R5: saturation over a long stuck-low
    phase = "R5";
    step(3 * T);
    chk(timeout == 1'b1, "R5", "timeout_o held", timeout, 1);

    // R4: release timing
    phase = "R4";
    txd = 1'b1;
    #0.5 chk(drv_dom == 1'b0, "R4", "drv_dom_o on release", drv_dom, 0);
    step(S);
    chk(timeout == 1'b1, "R4", "timeout_o before clear", timeout, 1);
    step(1);
    chk(timeout == 1'b0, "R4", "timeout_o cleared", timeout, 0);
    txd = 1'b0; step(1);
    chk(drv_dom == 1'b1, "R4", "drv_dom_o re-armed", drv_dom, 1);
    // one-cycle high glitch restarts the window
    step(T - 5);
    txd = 1'b1; step(1); txd = 1'b0;
    step(T);
    chk(timeout == 1'b0, "R4", "timeout_o after glitch restart", timeout, 0);
    step(S + 2);
    chk(timeout == 1'b1, "R4", "timeout_o after full window", timeout, 1);
    txd = 1'b1; step(S + 3);

    // R9: mode enable gates drive, not timer
    phase = "R9";
    mode_en = 1'b0; txd = 1'b0;
    step(2);
    chk(drv_dom == 1'b0, "R9", "drv_dom_o mode off", drv_dom, 0);
    step(S + T);
    chk(timeout == 1'b1, "R9", "timeout_o with mode off", timeout, 1);
    txd = 1'b1; mode_en = 1'b1; step(S + 3);

    // R6/R7: thermal shutdown and recovery rule
    phase = "R6";
    txd = 1'b0; step(2);
    ot = 1'b1;
    #0.5 chk(drv_dom == 1'b0, "R6", "drv_dom_o at overtemp", drv_dom, 0);
    step(1);
    chk(thermal == 1'b1, "R6", "thermal_o set", thermal, 1);
    step(3);
    phase = "R7";
    ot = 1'b0; step(4);
    chk(thermal == 1'b1, "R7", "thermal_o held while txd low", thermal, 1);
    chk(drv_dom == 1'b0, "R7", "drv_dom_o held off", drv_dom, 0);
    txd = 1'b1;
    step(S);
    chk(thermal == 1'b1, "R7", "thermal_o before sync high", thermal, 1);
    step(1);
    chk(thermal == 1'b0, "R7", "thermal_o released", thermal, 0);
    txd = 1'b0; step(1);
    chk(drv_dom == 1'b1, "R7", "drv_dom_o recovered", drv_dom, 1);
    txd = 1'b1; step(5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule